// File: doc/BRIEF.md
# Video Pixel Packer with Frame Wrapping

This block takes a stream of 16-bit YUV 4:2:2 pixels, each beat with a vertical sync and a data-enable flag, from one of two sources: the on-chip pattern source or an external pixel input. It combines each pair of consecutive pixels into one 32-bit word. It puts a fixed three-word header in front of every frame and closes every frame with a single terminator byte. Each word leaves the block with a 4-bit byte-enable mask, so a downstream buffer knows which bytes are meaningful.

A frame opens on a rising edge of vertical sync. It closes on its own after the last pixel of the configured number of active lines. It can also be cut short at any time with a close request, which emits the terminator immediately. All logic runs in one clock domain. Outputs are registered, and a word appears two clock edges after the input beat that produced it.

Top module: `yuv_frame_packer`

## Requirements
- R1: While reset is high and in every cycle where `out_valid` is low, `out_data` and `out_be` are zero.
- R2: A rising edge of the selected vertical sync, seen while no frame is open, produces three header words in consecutive cycles: 0x0000820C, then 0xBABEFACE, then 0xBABEFACE, each with `out_be` = 4'b1111. The header always comes before any other word of the frame.
- R3: Within a line, pixel 2k goes to `out_data[15:0]` and pixel 2k+1 goes to `out_data[31:16]` of one word, with `out_be` = 4'b1111.
- R4: When data-enable falls on active line number ACTIVE_LINES of a frame, and any pad word for that line has been sent, one terminator word 0x00000055 with `out_be` = 4'b0001 follows. Only the masks 4'b1111, 4'b0011 and 4'b0001 ever appear with `out_valid`.
- R5: A line with an odd pixel count ends with a word holding the last pixel in bits [15:0], zero in bits [31:16], and `out_be` = 4'b0011.
- R6: A `close_req` beat inside an open frame discards the pixel sampled with it, any unpaired pixel and everything after it until the next frame, and emits the terminator. If the request arrives while the header is being sent, the full header is sent first and the terminator follows it.
- R7: Pixels and `close_req` presented while no frame is open produce no output word.
- R8: `src_sel` = 0 selects the internal bus (`int_*`) and `src_sel` = 1 selects the external bus (`ext_*`). The sync, enable and pixel inputs of the unselected bus have no effect on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| src_sel | input | 1 | Source select: 0 internal, 1 external |
| int_vsync | input | 1 | Internal source vertical sync |
| int_de | input | 1 | Internal source data enable |
| int_pix | input | PIX_W | Internal source pixel |
| ext_vsync | input | 1 | External source vertical sync |
| ext_de | input | 1 | External source data enable |
| ext_pix | input | PIX_W | External source pixel |
| close_req | input | 1 | Request to end the current frame now |
| out_valid | output | 1 | Output word is valid |
| out_data | output | 2*PIX_W | Packed header, pixel or terminator word |
| out_be | output | PIX_W/4 | Byte enables of the output word |

## Verification
The bench builds the block with ACTIVE_LINES = 3 and keeps the default 16-bit pixel width. With only three lines per frame, the self-ending terminator is reached within a few dozen cycles, so one run can cover many frames. Those frames vary the line length (even, odd, single pixel), the source selection and the point of an early close. The default of 480 lines is only elaborated, which checks that the line counter width scales with it.

// File: rtl/yfp_pkg.sv
package yfp_pkg;
  localparam int PIX_W  = 16;
  localparam int WORD_W = 2 * PIX_W;
  localparam int BE_W   = WORD_W / 8;

  localparam logic [WORD_W-1:0] HDR_FIRST  = 32'h0000_820C;
  localparam logic [WORD_W-1:0] HDR_MARKER = 32'hBABE_FACE;
  localparam logic [WORD_W-1:0] TERM_WORD  = WORD_W'(8'h55);

  localparam logic [BE_W-1:0] BE_FULL = {BE_W{1'b1}};
  localparam logic [BE_W-1:0] BE_HALF = {{(BE_W/2){1'b0}}, {(BE_W/2){1'b1}}};
  localparam logic [BE_W-1:0] BE_TERM = BE_W'(1);

  typedef struct packed {
    logic             close;
    logic             vsync;
    logic             de;
    logic [PIX_W-1:0] pix;
  } beat_t;

  function automatic logic [WORD_W-1:0] hdr_word(input logic [1:0] idx);
    return (idx == 2'd0) ? HDR_FIRST : HDR_MARKER;
  endfunction
endpackage

// File: rtl/yfp_src_stage.sv
module yfp_src_stage
  import yfp_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             src_sel,
  input  logic             int_vsync,
  input  logic             int_de,
  input  logic [PIX_W-1:0] int_pix,
  input  logic             ext_vsync,
  input  logic             ext_de,
  input  logic [PIX_W-1:0] ext_pix,
  input  logic             close_req,
  output beat_t            beat
);
  beat_t cand [2];

  always_comb begin
    cand[0] = '{close: close_req, vsync: int_vsync, de: int_de, pix: int_pix};
    cand[1] = '{close: close_req, vsync: ext_vsync, de: ext_de, pix: ext_pix};
  end

  always_ff @(posedge clk) begin
    if (rst) beat <= '0;
    else     beat <= cand[src_sel];
  end
endmodule

// File: rtl/yfp_frame_track.sv
module yfp_frame_track #(
  parameter int ACTIVE_LINES = 480
) (
  input  logic clk,
  input  logic rst,
  input  logic vsync,
  input  logic de,
  output logic sof,
  output logic line_end,
  output logic last_line
);
  localparam int LINE_W = $clog2(ACTIVE_LINES + 1);

  logic              prev_vs;
  logic              prev_de;
  logic [LINE_W-1:0] line_cnt;

  assign sof       = vsync & ~prev_vs;
  assign line_end  = prev_de & ~de;
  assign last_line = (line_cnt == LINE_W'(ACTIVE_LINES - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_vs  <= 1'b0;
      prev_de  <= 1'b0;
      line_cnt <= '0;
    end else begin
      prev_vs <= vsync;
      prev_de <= de;
      if (sof)           line_cnt <= '0;
      else if (line_end) line_cnt <= line_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/yfp_word_pack.sv
module yfp_word_pack
  import yfp_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  beat_t             beat,
  input  logic              sof,
  input  logic              line_end,
  input  logic              last_line,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_data,
  output logic [BE_W-1:0]   out_be
);
  typedef enum logic [1:0] {ST_IDLE, ST_HDR, ST_BODY, ST_TERM} state_t;

  state_t           st;
  logic [1:0]       hdr_idx;
  logic             cls_pend;
  logic             held_v;
  logic [PIX_W-1:0] held_px;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      hdr_idx   <= '0;
      cls_pend  <= 1'b0;
      held_v    <= 1'b0;
      held_px   <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_be    <= '0;
    end else begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_be    <= '0;
      case (st)
        ST_IDLE: begin
          if (sof) begin
            out_valid <= 1'b1;
            out_data  <= hdr_word(2'd0);
            out_be    <= BE_FULL;
            hdr_idx   <= 2'd1;
            cls_pend  <= beat.close;
            held_v    <= 1'b0;
            st        <= ST_HDR;
          end
        end
        ST_HDR: begin
          out_valid <= 1'b1;
          out_data  <= hdr_word(hdr_idx);
          out_be    <= BE_FULL;
          hdr_idx   <= hdr_idx + 2'd1;
          if (beat.close) cls_pend <= 1'b1;
          if (hdr_idx == 2'd2)
            st <= (cls_pend | beat.close) ? ST_TERM : ST_BODY;
        end
        ST_BODY: begin
          if (beat.close) begin
            out_valid <= 1'b1;
            out_data  <= TERM_WORD;
            out_be    <= BE_TERM;
            held_v    <= 1'b0;
            st        <= ST_IDLE;
          end else if (beat.de) begin
            if (held_v) begin
              out_valid <= 1'b1;
              out_data  <= {beat.pix, held_px};
              out_be    <= BE_FULL;
              held_v    <= 1'b0;
            end else begin
              held_px <= beat.pix;
              held_v  <= 1'b1;
            end
          end else if (line_end) begin
            if (held_v) begin
              out_valid <= 1'b1;
              out_data  <= {{PIX_W{1'b0}}, held_px};
              out_be    <= BE_HALF;
              held_v    <= 1'b0;
            end
            if (last_line) st <= ST_TERM;
          end
        end
        ST_TERM: begin
          out_valid <= 1'b1;
          out_data  <= TERM_WORD;
          out_be    <= BE_TERM;
          st        <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/yuv_frame_packer.sv
module yuv_frame_packer
  import yfp_pkg::*;
#(
  parameter int ACTIVE_LINES = 480
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              src_sel,
  input  logic              int_vsync,
  input  logic              int_de,
  input  logic [PIX_W-1:0]  int_pix,
  input  logic              ext_vsync,
  input  logic              ext_de,
  input  logic [PIX_W-1:0]  ext_pix,
  input  logic              close_req,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_data,
  output logic [BE_W-1:0]   out_be
);
  beat_t beat;
  logic  sof;
  logic  line_end;
  logic  last_line;

  yfp_src_stage u_src (
    .clk       (clk),
    .rst       (rst),
    .src_sel   (src_sel),
    .int_vsync (int_vsync),
    .int_de    (int_de),
    .int_pix   (int_pix),
    .ext_vsync (ext_vsync),
    .ext_de    (ext_de),
    .ext_pix   (ext_pix),
    .close_req (close_req),
    .beat      (beat)
  );

  yfp_frame_track #(.ACTIVE_LINES(ACTIVE_LINES)) u_track (
    .clk       (clk),
    .rst       (rst),
    .vsync     (beat.vsync),
    .de        (beat.de),
    .sof       (sof),
    .line_end  (line_end),
    .last_line (last_line)
  );

  yfp_word_pack u_pack (
    .clk       (clk),
    .rst       (rst),
    .beat      (beat),
    .sof       (sof),
    .line_end  (line_end),
    .last_line (last_line),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_be    (out_be)
  );
endmodule

// File: rtl/yfp_checker.sv
module yfp_checker
  import yfp_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              out_valid,
  input logic [WORD_W-1:0] out_data,
  input logic [BE_W-1:0]   out_be
);
  logic after_term;

  always_ff @(posedge clk) begin
    if (rst) after_term <= 1'b1;
    else if (out_valid) after_term <= (out_be == BE_TERM);
  end

  assert_quiet_idle_R1: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (out_data == '0 && out_be == '0));

  assert_header_first_R2: assert property (@(posedge clk) disable iff (rst)
    (out_valid && after_term) |-> (out_data == HDR_FIRST && out_be == BE_FULL));

  assert_be_legal_R4: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_be == BE_FULL || out_be == BE_HALF || out_be == BE_TERM));

  assert_term_value_R4: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_be == BE_TERM) |-> (out_data == TERM_WORD));

  assert_pad_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_be == BE_HALF) |-> (out_data[WORD_W-1:PIX_W] == '0));
endmodule

bind yuv_frame_packer yfp_checker u_yfp_checker (
  .clk       (clk),
  .rst       (rst),
  .out_valid (out_valid),
  .out_data  (out_data),
  .out_be    (out_be)
);

// File: tb/test_yuv_frame_packer.sv
module test_yuv_frame_packer;
  localparam int LINES = 3;

  typedef struct {
    logic [31:0] d;
    logic [3:0]  be;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        src_sel = 1'b0;
  logic        int_vsync = 1'b0, int_de = 1'b0;
  logic [15:0] int_pix = '0;
  logic        ext_vsync = 1'b0, ext_de = 1'b0;
  logic [15:0] ext_pix = '0;
  logic        close_req = 1'b0;
  logic        out_valid;
  logic [31:0] out_data;
  logic [3:0]  out_be;

  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;
  exp_t exp_q[$];
  exp_t cur;

  always #2 clk = ~clk;

  yuv_frame_packer #(.ACTIVE_LINES(LINES)) i_yuv_frame_packer (
    .clk(clk), .rst(rst), .src_sel(src_sel),
    .int_vsync(int_vsync), .int_de(int_de), .int_pix(int_pix),
    .ext_vsync(ext_vsync), .ext_de(ext_de), .ext_pix(ext_pix),
    .close_req(close_req),
    .out_valid(out_valid), .out_data(out_data), .out_be(out_be)
  );

  task automatic push(input logic [31:0] d, input logic [3:0] be, input string tag);
    exp_t e;
    e.d = d; e.be = be; e.tag = tag;
    exp_q.push_back(e);
  endtask

  // Drives one beat on the selected bus; the other bus gets the inverse.
  task automatic beat(input logic vs, input logic de, input logic [15:0] px, input logic cl);
    if (src_sel) begin
      ext_vsync = vs;  ext_de = de;  ext_pix = px;
      int_vsync = ~vs; int_de = ~de; int_pix = ~px;
    end else begin
      int_vsync = vs;  int_de = de;  int_pix = px;
      ext_vsync = ~vs; ext_de = ~de; ext_pix = ~px;
    end
    close_req = cl;
    @(posedge clk); #1;
  endtask

  // close_line = -1: close during header; close_line >= LINES: no close.
  task automatic frame(input logic src, input int ppl, input int close_line,
                       input int close_pix, input int seed, input string tag);
    bit          closed;
    bit          held;
    logic [15:0] held_px;
    closed = 1'b0;
    held   = 1'b0;
    held_px = '0;
    src_sel = src;
    beat(1'b0, 1'b0, 16'h0, 1'b0);
    beat(1'b0, 1'b0, 16'h0, 1'b0);
    push(32'h0000_820C, 4'hF, "R2");
    push(32'hBABE_FACE, 4'hF, "R2");
    push(32'hBABE_FACE, 4'hF, "R2");
    beat(1'b1, 1'b0, 16'h0, 1'b0);
    beat(1'b1, 1'b0, 16'h0, close_line == -1);
    if (close_line == -1) begin
      closed = 1'b1;
      push(32'h0000_0055, 4'h1, "R6");
    end
    beat(1'b1, 1'b0, 16'h0, 1'b0);
    beat(1'b1, 1'b0, 16'h0, 1'b0);
    for (int l = 0; l < LINES; l++) begin
      for (int p = 0; p < ppl; p++) begin
        logic [15:0] px;
        bit          cl;
        px = 16'(seed + l * 256 + p * 3);
        cl = !closed && l == close_line && p == close_pix;
        beat(1'b0, 1'b1, px, cl);
        if (cl) begin
          closed = 1'b1;
          held   = 1'b0;
          push(32'h0000_0055, 4'h1, "R6");
        end else if (!closed) begin
          if (held) begin
            push({px, held_px}, 4'hF, tag);
            held = 1'b0;
          end else begin
            held_px = px;
            held    = 1'b1;
          end
        end
      end
      beat(1'b0, 1'b0, 16'h0, 1'b0);
      beat(1'b0, 1'b0, 16'h0, 1'b0);
      if (!closed && held) begin
        push({16'h0, held_px}, 4'h3, "R5");
        held = 1'b0;
      end
      if (!closed && l == LINES - 1) push(32'h0000_0055, 4'h1, "R4");
    end
    for (int i = 0; i < 6; i++) beat(1'b0, 1'b0, 16'h0, 1'b0);
  endtask

  // Monitor: pops and compares every valid word.
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R7 unexpected word: actual %h/%h expected none", out_data, out_be);
      end else begin
        cur = exp_q.pop_front();
        if (out_data !== cur.d || out_be !== cur.be) begin
          errors++;
          $display("FAIL %s word: actual %h/%h expected %h/%h",
                   cur.tag, out_data, out_be, cur.d, cur.be);
        end
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || out_data !== 32'h0 || out_be !== 4'h0) begin
      errors++;
      $display("FAIL R1 reset outputs: actual %b/%h/%h expected 0/0/0", out_valid, out_data, out_be);
    end
    @(posedge clk); #1;
    rst = 1'b0;
    // R7: pixels and close requests with no open frame.
    for (int i = 0; i < 5; i++) beat(1'b0, 1'b1, 16'(16'h1234 + i), i == 2);
    beat(1'b0, 1'b0, 16'h0, 1'b1);
    // R2 R3 R4: even line, internal source.
    frame(1'b0, 6, LINES, 0, 16'h0100, "R3");
    // R5 R8: odd line, external source.
    frame(1'b1, 5, LINES, 0, 16'h4000, "R8");
    // R6: close inside a line with an unpaired pixel pending.
    frame(1'b0, 7, 1, 3, 16'h2000, "R3");
    // R6: close while the header is going out, external source.
    frame(1'b1, 4, -1, 0, 16'h6000, "R8");
    // R5: single-pixel lines.
    frame(1'b0, 1, LINES, 0, 16'h7000, "R3");
    // R7: close request after the frame has ended.
    beat(1'b0, 1'b0, 16'h0, 1'b1);
    frame(1'b1, 8, 2, 4, 16'h3000, "R8");
    repeat (10) @(posedge clk);
    @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R4 missing words: actual %0d pending expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule